// File: doc/BRIEF.md
# Multi-mode L1 memory

This block is a small first-level memory array that can serve a core in one of three ways, chosen through a mode register. In cache mode it behaves as a direct-mapped, write-through cache: read misses fetch one line over a simple request/acknowledge memory port, and every write is forwarded to memory. In scratchpad mode the same rows form a directly addressed local RAM. In self-test mode, which is where the block starts after reset, the lowest rows hold a built-in liveness program. A core can therefore fetch and run code from a bare chip without any outside memory.

The built-in program is rebuilt from a computed constant on every reset. Each instruction occupies one 8-byte row. The program ends with a jump back to byte address 0x40, and just before that jump sits an instruction that a core decodes as "toggle the liveness pin". A separate debug port can read and write any row at any time, independent of the core port and of the mode.

Top module: `l1mm_top`

## Requirements
- R1: While reset is asserted and right after it, mode_out is 2'b00 (self-test), core_busy and mem_req are low, and rows at or above BOOT_ROWS (32) read as zero.
- R2: After reset, row i (byte address 8*i, bits [2:0] ignored) below BOOT_ROWS holds {opcode[63:56], operand[55:0]}: row 30 (0xF0) holds opcode 0x7E (toggle) with operand 0, row 31 (0xF8) holds opcode 0xE0 (jump) with operand 0x40, and every other such row holds opcode 0x01 with the row index as operand.
- R3: In scratchpad or self-test mode, a request taken while core_busy is low gives a one-cycle core_ready in the next cycle. A read returns the row at core_addr[8:3], a write returns zero data, and in scratchpad mode every in-range row, including the program rows, is writable.
- R4: In self-test mode, core writes to rows below BOOT_ROWS are dropped without error, and writes to rows at or above BOOT_ROWS take effect.
- R5: In scratchpad or self-test mode, an address with any of bits [15:9] set is out of range. Such an access returns zero data with core_err high during core_ready, and a write to it changes no row.
- R6: Mode codes are 2'b00 self-test, 2'b01 scratchpad and 2'b10 cache. A cfg_we write takes effect the next cycle only when the code is not 2'b11, core_busy is low and core_req is low in the same cycle; otherwise the write is ignored.
- R7: In cache mode, a read miss raises one mem_req with mem_we low and the 8-byte-aligned address. The request is held until mem_ack, core_busy stays high meanwhile, and core_ready comes the cycle after mem_ack with mem_rdata. Later reads of that line hit with no memory request. A second tag that maps to the same row evicts the line.
- R8: In cache mode, every write raises a mem_req with mem_we high, the aligned address and the write data. core_ready follows in the next cycle, and core_busy stays high until mem_ack. A hit updates the stored line; a miss allocates nothing.
- R9: Leaving cache mode invalidates every line, so after re-entry a previously cached address misses. The row contents themselves are kept and are visible in scratchpad mode.
- R10: A debug request reads row dbg_row onto dbg_rdata in the next cycle, or writes it with dbg_wdata in any mode (program rows included). It has no effect on core_busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req | input | 1 | Core access request |
| core_we | input | 1 | Core access is a write |
| core_addr | input | 16 | Core byte address |
| core_wdata | input | 64 | Core write data |
| core_busy | output | 1 | Block cannot take a request |
| core_ready | output | 1 | One-cycle response strobe |
| core_rdata | output | 64 | Response data |
| core_err | output | 1 | Out-of-range access flag, valid with core_ready |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 16 | Aligned memory address |
| mem_wdata | output | 64 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 64 | Fill data, valid with mem_ack |
| dbg_req | input | 1 | Debug access request |
| dbg_we | input | 1 | Debug access is a write |
| dbg_row | input | 6 | Debug row index |
| dbg_wdata | input | 64 | Debug write data |
| dbg_rdata | output | 64 | Debug read data |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_mode | input | 2 | Requested mode code |
| mode_out | output | 2 | Current mode code |

## Verification
The local modes are driven with a table of reads and writes that mixes program rows, the highest row and out-of-range addresses. This separates correct row decoding from wrap-around aliasing and shows that rejected writes leave the rows untouched. The cache is tried with a cold miss, a same-line hit at a different offset, a conflicting tag on the same row, and write hits and write misses. Comparing the bench's memory-request counts across these cases tells allocation, eviction and no-allocate-on-write apart. Mode writes are attempted while a miss is outstanding and alongside a core request, and a leave-and-return cycle of cache mode shows that invalidation is separate from data retention.

// File: rtl/l1mm_pkg.sv
package l1mm_pkg;

   typedef enum logic [1:0] {
      MODE_SELFTEST = 2'b00,
      MODE_SPAD     = 2'b01,
      MODE_CACHE    = 2'b10
   } mode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'b00,
      ST_MISS  = 2'b01,
      ST_WPOST = 2'b10
   } ctl_state_e;

   localparam logic [7:0] OP_ALU    = 8'h01;
   localparam logic [7:0] OP_TOGGLE = 8'h7E;
   localparam logic [7:0] OP_JUMP   = 8'hE0;
   localparam int         LOOP_ROW  = 8;

   // Liveness program: last row jumps back to LOOP_ROW, the row before toggles the pin.
   function automatic logic [63:0] boot_word(int unsigned row, int unsigned n_rows);
      if (row == n_rows - 1)
         return {OP_JUMP, 56'(LOOP_ROW * 8)};
      else if (row == n_rows - 2)
         return {OP_TOGGLE, 56'd0};
      else
         return {OP_ALU, 56'(row)};
   endfunction

endpackage

// File: rtl/l1mm_store.sv
module l1mm_store
   import l1mm_pkg::*;
#(
   parameter int ROWS      = 64,
   parameter int DATA_W    = 64,
   parameter int BOOT_ROWS = 32,
   localparam int ROW_W    = $clog2(ROWS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ROW_W-1:0]  rd_row,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [ROW_W-1:0]  wr_row,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              dbg_req,
   input  logic              dbg_we,
   input  logic [ROW_W-1:0]  dbg_row,
   input  logic [DATA_W-1:0] dbg_wdata,
   output logic [DATA_W-1:0] dbg_rdata
);

   logic [DATA_W-1:0] mem [ROWS];

   // Core-side write is placed last so it wins a same-row collision with debug.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < ROWS; r++)
            mem[r] <= (r < BOOT_ROWS) ? DATA_W'(boot_word(r, BOOT_ROWS)) : '0;
      end else begin
         if (dbg_req && dbg_we) mem[dbg_row] <= dbg_wdata;
         if (wr_en)             mem[wr_row]  <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  dbg_rdata <= '0;
      else if (dbg_req && !dbg_we) dbg_rdata <= mem[dbg_row];
   end

   assign rd_data = mem[rd_row];

endmodule

// File: rtl/l1mm_tags.sv
module l1mm_tags #(
   parameter int ROWS  = 64,
   parameter int TAG_W = 7,
   localparam int ROW_W = $clog2(ROWS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ROW_W-1:0] lk_row,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             hit,
   input  logic             fill_en,
   input  logic [ROW_W-1:0] fill_row,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic             clr_all
);

   logic [ROWS-1:0]  valid_q;
   logic [TAG_W-1:0] tag_mem [ROWS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       valid_q <= '0;
      else if (clr_all) valid_q <= '0;
      else if (fill_en) valid_q[fill_row] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (fill_en) tag_mem[fill_row] <= fill_tag;
   end

   assign hit = valid_q[lk_row] && (tag_mem[lk_row] == lk_tag);

   // R7: a completed fill makes its row valid for the next lookup
   a_r7_fill_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && !clr_all) |=> valid_q[$past(fill_row)]);

endmodule

// File: rtl/l1mm_top.sv
module l1mm_top
   import l1mm_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int DATA_W       = 64,
   parameter int ROWS         = 64,
   parameter int BOOT_ROWS    = 32,
   parameter bit PROTECT_BOOT = 1'b1,
   localparam int ROW_W       = $clog2(ROWS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              core_req,
   input  logic              core_we,
   input  logic [ADDR_W-1:0] core_addr,
   input  logic [DATA_W-1:0] core_wdata,
   output logic              core_busy,
   output logic              core_ready,
   output logic [DATA_W-1:0] core_rdata,
   output logic              core_err,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              dbg_req,
   input  logic              dbg_we,
   input  logic [ROW_W-1:0]  dbg_row,
   input  logic [DATA_W-1:0] dbg_wdata,
   output logic [DATA_W-1:0] dbg_rdata,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_mode,
   output logic [1:0]        mode_out
);

   localparam int OFF_W = $clog2(DATA_W / 8);
   localparam int TAG_W = ADDR_W - ROW_W - OFF_W;

   initial begin
      a_cfg_rows_pow2: assert ((1 << ROW_W) == ROWS)
         else $fatal(1, "ROWS must be a power of two");
      a_cfg_boot_fits: assert (BOOT_ROWS <= ROWS && BOOT_ROWS > LOOP_ROW + 2)
         else $fatal(1, "BOOT_ROWS out of range");
      a_cfg_width: assert (DATA_W >= 64 && TAG_W >= 1)
         else $fatal(1, "DATA_W or ADDR_W too small");
   end

   mode_e              mode_q;
   ctl_state_e         state_q;
   logic [ROW_W-1:0]   row_in, miss_row_q;
   logic [TAG_W-1:0]   tag_in, miss_tag_q;
   logic               in_range, local_mode, accept, tag_hit, boot_lock;
   logic               mode_acc, clr_all, fill_en, st_wr_en;
   logic [ROW_W-1:0]   st_wr_row;
   logic [DATA_W-1:0]  st_wr_data, st_rd_data;
   logic [ADDR_W-1:0]  line_addr;

   assign row_in     = core_addr[OFF_W +: ROW_W];
   assign tag_in     = core_addr[ADDR_W-1 -: TAG_W];
   assign in_range   = (tag_in == '0);
   assign line_addr  = core_addr & ~ADDR_W'((1 << OFF_W) - 1);
   assign local_mode = (mode_q != MODE_CACHE);
   assign accept     = core_req && (state_q == ST_IDLE);
   assign core_busy  = (state_q != ST_IDLE);
   assign fill_en    = (state_q == ST_MISS) && mem_ack;

   // Variant: program rows either locked or writable while in self-test mode.
   generate
      if (PROTECT_BOOT) begin : g_lock
         assign boot_lock = (mode_q == MODE_SELFTEST) && (int'(row_in) < BOOT_ROWS);
      end else begin : g_open
         assign boot_lock = 1'b0;
      end
   endgenerate

   assign mode_acc = cfg_we && !core_busy && !core_req && (cfg_mode != 2'b11);
   assign clr_all  = mode_acc && (mode_q == MODE_CACHE) && (cfg_mode != MODE_CACHE);

   assign st_wr_en   = fill_en ||
                       (accept && core_we && (local_mode ? (in_range && !boot_lock) : tag_hit));
   assign st_wr_row  = fill_en ? miss_row_q : row_in;
   assign st_wr_data = fill_en ? mem_rdata  : core_wdata;

   l1mm_store #(.ROWS(ROWS), .DATA_W(DATA_W), .BOOT_ROWS(BOOT_ROWS)) u_store (
      .clk(clk), .rst_n(rst_n),
      .rd_row(row_in), .rd_data(st_rd_data),
      .wr_en(st_wr_en), .wr_row(st_wr_row), .wr_data(st_wr_data),
      .dbg_req(dbg_req), .dbg_we(dbg_we), .dbg_row(dbg_row),
      .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata)
   );

   l1mm_tags #(.ROWS(ROWS), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .rst_n(rst_n),
      .lk_row(row_in), .lk_tag(tag_in), .hit(tag_hit),
      .fill_en(fill_en), .fill_row(miss_row_q), .fill_tag(miss_tag_q),
      .clr_all(clr_all)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_SELFTEST;
      else if (mode_acc) mode_q <= mode_e'(cfg_mode);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         core_ready <= 1'b0;
         core_err   <= 1'b0;
         core_rdata <= '0;
         mem_req    <= 1'b0;
         mem_we     <= 1'b0;
         mem_addr   <= '0;
         mem_wdata  <= '0;
         miss_row_q <= '0;
         miss_tag_q <= '0;
      end else begin
         core_ready <= 1'b0;
         core_err   <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (accept) begin
               if (local_mode) begin
                  core_ready <= 1'b1;
                  core_err   <= !in_range;
                  core_rdata <= (in_range && !core_we) ? st_rd_data : '0;
               end else if (core_we) begin
                  core_ready <= 1'b1;
                  core_rdata <= '0;
                  mem_req    <= 1'b1;
                  mem_we     <= 1'b1;
                  mem_addr   <= line_addr;
                  mem_wdata  <= core_wdata;
                  state_q    <= ST_WPOST;
               end else if (tag_hit) begin
                  core_ready <= 1'b1;
                  core_rdata <= st_rd_data;
               end else begin
                  mem_req    <= 1'b1;
                  mem_we     <= 1'b0;
                  mem_addr   <= line_addr;
                  miss_row_q <= row_in;
                  miss_tag_q <= tag_in;
                  state_q    <= ST_MISS;
               end
            end
            ST_MISS: if (mem_ack) begin
               mem_req    <= 1'b0;
               core_ready <= 1'b1;
               core_rdata <= mem_rdata;
               state_q    <= ST_IDLE;
            end
            ST_WPOST: if (mem_ack) begin
               mem_req <= 1'b0;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mode_out = mode_q;

   // R7: an outstanding request keeps its kind and address until acknowledged
   a_r7_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R7: the memory port is used only in cache mode
   a_r7_cache_only: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mode_q == MODE_CACHE));

   // R6: the mode changes only after a write taken while idle
   a_r6_mode_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mode_q) |-> ($past(cfg_we) && !$past(core_busy) && !$past(core_req)));

   // R9: outside cache mode no line is valid
   a_r9_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != MODE_CACHE) |-> !tag_hit);

   // R5: an error response carries zero data
   a_r5_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
      core_err |-> (core_ready && core_rdata == '0));

   // R3: a response follows an accepted request or a fill
   a_r3_ready_src: assert property (@(posedge clk) disable iff (!rst_n)
      core_ready |-> ($past(accept) || $past(fill_en)));

endmodule

// File: tb/tb_l1mm_top.sv
module tb_l1mm_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        core_req = 1'b0, core_we = 1'b0;
   logic [15:0] core_addr = '0;
   logic [63:0] core_wdata = '0;
   logic        core_busy, core_ready, core_err;
   logic [63:0] core_rdata;
   logic        mem_req, mem_we;
   logic [15:0] mem_addr;
   logic [63:0] mem_wdata;
   logic        mem_ack = 1'b0;
   logic [63:0] mem_rdata = '0;
   logic        dbg_req = 1'b0, dbg_we = 1'b0;
   logic [5:0]  dbg_row = '0;
   logic [63:0] dbg_wdata = '0;
   logic [63:0] dbg_rdata;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_mode = '0;
   logic [1:0]  mode_out;

   int n_chk = 0, n_fail = 0;
   int rd_cnt = 0, wr_cnt = 0;
   logic [15:0] last_addr = '0;
   logic [63:0] last_wdata = '0;
   bit done = 0;

   always #5 clk = ~clk;

   l1mm_top dut (
      .clk(clk), .rst_n(rst_n),
      .core_req(core_req), .core_we(core_we), .core_addr(core_addr), .core_wdata(core_wdata),
      .core_busy(core_busy), .core_ready(core_ready), .core_rdata(core_rdata), .core_err(core_err),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .dbg_req(dbg_req), .dbg_we(dbg_we), .dbg_row(dbg_row), .dbg_wdata(dbg_wdata),
      .dbg_rdata(dbg_rdata),
      .cfg_we(cfg_we), .cfg_mode(cfg_mode), .mode_out(mode_out)
   );

   function automatic logic [63:0] fill_of(logic [15:0] a);
      return 64'hD00D_0000_0000_0000 | 64'(a);
   endfunction

   function automatic logic [63:0] prog(int i);
      if (i == 31) return 64'hE000_0000_0000_0040;
      if (i == 30) return 64'h7E00_0000_0000_0000;
      return {8'h01, 56'(i)};
   endfunction

   // Memory model: acknowledge each request on the third falling edge it is seen.
   initial begin
      int dly;
      dly = 0;
      forever begin
         @(negedge clk);
         if (mem_req && !mem_ack) begin
            if (dly == 2) begin
               mem_ack   = 1'b1;
               mem_rdata = fill_of(mem_addr);
               last_addr = mem_addr;
               if (mem_we) begin wr_cnt++; last_wdata = mem_wdata; end
               else rd_cnt++;
               dly = 0;
            end else dly++;
         end else mem_ack = 1'b0;
      end
   end

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic access(input logic we, input logic [15:0] a, input logic [63:0] wd,
                         output logic [63:0] rd, output logic er);
      int t;
      t = 0;
      while (core_busy) @(negedge clk);
      core_req = 1'b1; core_we = we; core_addr = a; core_wdata = wd;
      @(negedge clk);
      core_req = 1'b0; core_we = 1'b0;
      while (!core_ready && t < 50) begin @(negedge clk); t++; end
      rd = core_rdata; er = core_err;
      @(negedge clk);
   endtask

   task automatic set_mode(input logic [1:0] m);
      while (core_busy) @(negedge clk);
      cfg_we = 1'b1; cfg_mode = m;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic dbg_access(input logic we, input logic [5:0] r, input logic [63:0] wd,
                             output logic [63:0] rd);
      dbg_req = 1'b1; dbg_we = we; dbg_row = r; dbg_wdata = wd;
      @(negedge clk);
      dbg_req = 1'b0; dbg_we = 1'b0;
      rd = dbg_rdata;
   endtask

   typedef struct packed {
      logic        we;
      logic [15:0] addr;
      logic [63:0] wd;
      logic [63:0] exp;
      logic        err;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VT [NV] = '{
      '{1'b0, 16'h0000, 64'h0,    64'h0100_0000_0000_0000, 1'b0},
      '{1'b0, 16'h00F8, 64'h0,    64'hE000_0000_0000_0040, 1'b0},
      '{1'b1, 16'h0008, 64'h1111, 64'h0,                   1'b0},
      '{1'b0, 16'h0008, 64'h0,    64'h1111,                1'b0},
      '{1'b1, 16'h01F8, 64'hCAFE, 64'h0,                   1'b0},
      '{1'b0, 16'h01F8, 64'h0,    64'hCAFE,                1'b0},
      '{1'b0, 16'h0200, 64'h0,    64'h0,                   1'b1},
      '{1'b1, 16'h0208, 64'hBEEF, 64'h0,                   1'b1},
      '{1'b0, 16'h0008, 64'h0,    64'h1111,                1'b0}
   };

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [63:0] rd;
      logic        er;
      int          base;

      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 mode in reset", 64'(mode_out), 64'h0);
      check("R1 busy in reset", 64'(core_busy), 64'h0);
      check("R1 mem_req in reset", 64'(mem_req), 64'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 / R1: program contents in self-test mode
      access(1'b0, 16'h00F0, '0, rd, er); check("R2 toggle row", rd, prog(30));
      access(1'b0, 16'h0010, '0, rd, er); check("R2 alu row", rd, prog(2));
      access(1'b0, 16'h0100, '0, rd, er); check("R1 upper row zero", rd, 64'h0);

      // R4: program rows locked in self-test mode
      access(1'b1, 16'h0010, 64'h5555, rd, er); check("R4 locked write no err", 64'(er), 64'h0);
      access(1'b0, 16'h0010, '0, rd, er);       check("R4 locked row kept", rd, prog(2));
      access(1'b1, 16'h0140, 64'h7777, rd, er);
      access(1'b0, 16'h0140, '0, rd, er);       check("R4 upper row written", rd, 64'h7777);

      // R10: debug port
      dbg_access(1'b0, 6'd31, '0, rd); check("R10 debug read", rd, prog(31));
      dbg_access(1'b1, 6'd3, 64'hABCD, rd);
      check("R10 debug no busy", 64'(core_busy), 64'h0);
      access(1'b0, 16'h0018, '0, rd, er); check("R10 debug write seen by core", rd, 64'hABCD);

      // R6: mode register
      set_mode(2'b11); check("R6 reserved code ignored", 64'(mode_out), 64'h0);
      set_mode(2'b01); check("R6 scratchpad code", 64'(mode_out), 64'h1);
      core_req = 1'b1; core_we = 1'b0; core_addr = 16'h0000;
      cfg_we = 1'b1; cfg_mode = 2'b10;
      @(negedge clk);
      core_req = 1'b0; cfg_we = 1'b0;
      @(negedge clk);
      check("R6 write with core_req ignored", 64'(mode_out), 64'h1);

      // R3 / R5: scratchpad vector table
      for (int i = 0; i < NV; i++) begin
         access(VT[i].we, VT[i].addr, VT[i].wd, rd, er);
         check($sformatf("R3 vector %0d data", i), rd, VT[i].exp);
         check($sformatf("R5 vector %0d err", i), 64'(er), 64'(VT[i].err));
      end

      // R7: cache read miss, hit, conflict
      set_mode(2'b10); check("R6 cache code", 64'(mode_out), 64'h2);
      access(1'b0, 16'h0100, '0, rd, er);
      check("R7 miss data", rd, fill_of(16'h0100));
      check("R7 one read request", 64'(rd_cnt), 64'd1);
      check("R7 request address", 64'(last_addr), 64'h0100);
      access(1'b0, 16'h0104, '0, rd, er);
      check("R7 same-line hit data", rd, fill_of(16'h0100));
      check("R7 hit no request", 64'(rd_cnt), 64'd1);
      access(1'b0, 16'h0300, '0, rd, er);
      check("R7 conflict miss data", rd, fill_of(16'h0300));
      access(1'b0, 16'h0100, '0, rd, er);
      check("R7 evicted line misses", 64'(rd_cnt), 64'd3);

      // R8: write-through
      access(1'b1, 16'h0100, 64'h1234_5678, rd, er);
      while (core_busy) @(negedge clk);
      check("R8 write request count", 64'(wr_cnt), 64'd1);
      check("R8 write address", 64'(last_addr), 64'h0100);
      check("R8 write data", last_wdata, 64'h1234_5678);
      access(1'b0, 16'h0100, '0, rd, er);
      check("R8 hit updated", rd, 64'h1234_5678);
      check("R8 hit no read request", 64'(rd_cnt), 64'd3);
      access(1'b1, 16'h0404, 64'h9999, rd, er);
      while (core_busy) @(negedge clk);
      check("R8 aligned write address", 64'(last_addr), 64'h0400);
      access(1'b0, 16'h0400, '0, rd, er);
      check("R8 no allocate on write miss", rd, fill_of(16'h0400));
      check("R8 read after write miss fetches", 64'(rd_cnt), 64'd4);

      // R6 / R7: mode write during an outstanding miss
      core_req = 1'b1; core_we = 1'b0; core_addr = 16'h0508;
      @(negedge clk);
      core_req = 1'b0;
      check("R7 busy during miss", 64'(core_busy), 64'h1);
      cfg_we = 1'b1; cfg_mode = 2'b01;
      @(negedge clk);
      cfg_we = 1'b0;
      begin
         int t;
         t = 0;
         while (!core_ready && t < 50) begin @(negedge clk); t++; end
      end
      check("R7 delayed fill data", core_rdata, fill_of(16'h0508));
      check("R6 busy mode write ignored", 64'(mode_out), 64'h2);
      @(negedge clk);

      // R9: leave and re-enter cache mode
      set_mode(2'b01);
      access(1'b0, 16'h0100, '0, rd, er);
      check("R9 row kept after leaving", rd, 64'h1234_5678);
      set_mode(2'b10);
      base = rd_cnt;
      access(1'b0, 16'h0100, '0, rd, er);
      check("R9 line invalidated", 64'(rd_cnt), 64'(base + 1));

      // R1: second reset restores program and mode
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 mode after reset", 64'(mode_out), 64'h0);
      dbg_access(1'b0, 6'd3, '0, rd); check("R1 program restored", rd, prog(3));
      access(1'b0, 16'h0140, '0, rd, er); check("R1 upper row cleared", rd, 64'h0);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule